// File: doc/BRIEF.md
# Blocking Message Channel Unit

The block sits between a processor core and several attached devices and carries 32-bit messages between them through a set of numbered channels. Each channel is a small queue with a fixed direction: core-to-device channels are filled by the core and drained by their device, and device-to-core channels are filled by their device and drained by the core. A device may own any number of channels. The core reaches every channel through one shared request port that carries an operation code, a channel number and a payload.

Because every channel holds several entries, the core can issue a burst of messages to a device on consecutive cycles with no delay until the queue is full. A write to a full channel or a read from an empty channel is not refused. The request stays pending, `core_wait` is raised so the core can drop into a low-power wait, and the access finishes in the cycle the device frees a slot or delivers a message. A count query returns the room or the backlog of a channel without ever stalling.

Top module: `msg_chan_unit`

## Requirements
- R1: There are 8 channels. Each holds up to 4 messages of 32 bits. Channels 0 to 3 are core-to-device and channels 4 to 7 are device-to-core, and the parameter `CH_DIR` sets this with bit c = 1 for core-to-device.
- R2: A write (`core_op`=2'b01) to a core-to-device channel that is not full completes in the same cycle with `core_done`=1 and `core_wait`=0. Four writes to an empty channel complete on four consecutive cycles, and the device receives the messages in write order.
- R3: A read (`core_op`=2'b00) from a device-to-core channel that holds data completes in the same cycle. `core_rdata` carries the oldest message, so messages come out in the order the device delivered them.
- R4: A write to a full channel, or a read from an empty channel, gives `core_done`=0 and `core_wait`=1 for as long as the device neither frees a slot nor supplies data.
- R5: A stalled write completes in the cycle where `dev_out_valid` and `dev_out_ready` of its channel are both high. A stalled read completes in the cycle where its channel's `dev_in_valid` is high, and it returns that cycle's `dev_in_data`. `core_wait` is low in that cycle.
- R6: A read of a core-to-device channel, or a write to a device-to-core channel, completes at once with `core_err`=1 and queues nothing.
- R7: A count query (`core_op`=2'b10) completes at once with `core_err`=0. Bits [2:0] of `core_rdata` hold the free entries for a core-to-device channel or the queued entries for a device-to-core channel, and the upper bits are zero.
- R8: An enqueue and a dequeue on the same channel in the same cycle leave its count unchanged. The count moves by at most one per cycle and never exceeds 4.
- R9: After reset every queue is empty, `dev_out_valid` is all zero, `dev_in_ready` is high for every device-to-core channel, and `core_wait` is low.
- R10: The reserved operation code 2'b11 completes at once with `core_err`=1. `core_wait` is only ever raised for a read or a write.
- R11: `dev_out_valid` of a core-to-device channel is high exactly while it holds a message, with the oldest message on `dev_out_data`. `dev_in_ready` of a device-to-core channel is low exactly while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core request pending, held until `core_done` |
| core_op | input | 2 | 00 read, 01 write, 10 count query, 11 reserved |
| core_ch | input | 3 | Channel number |
| core_wdata | input | 32 | Write payload |
| core_done | output | 1 | Request completes this cycle |
| core_err | output | 1 | Request completed with a direction or opcode error |
| core_wait | output | 1 | Core stalled on a channel, low-power wait |
| core_rdata | output | 32 | Read message or count |
| dev_out_valid | output | 8 | Per channel: message available to the device |
| dev_out_ready | input | 8 | Per channel: device takes the message |
| dev_out_data | output | 256 | Per channel oldest message, channel c at bits [32c+31:32c] |
| dev_in_valid | input | 8 | Per channel: device offers a message |
| dev_in_ready | output | 8 | Per channel: room for a device message |
| dev_in_data | input | 256 | Per channel device message, channel c at bits [32c+31:32c] |

## Verification
The bench goes after the edges of the queue. These include the fifth write into a full channel, the write that coincides with a device take on that full channel, and the read of an empty channel that coincides with a device delivery. A design that got the last case wrong would stall one cycle too long or would return stale queue contents in place of the bypassed word. Wrong-direction accesses and the reserved opcode are followed by count queries, so a design that queued them anyway would show up as a changed count. Random traffic with enqueues and dequeues on the same channel in the same cycle exposes a count that drifts, and with it a lost message or one delivered twice.

// File: rtl/msg_chan_pkg.sv
package msg_chan_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_COUNT = 2'b10,
    OP_RSVD  = 2'b11
  } chan_op_e;
endpackage

// File: rtl/msg_chan_fifo.sv
module msg_chan_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              state_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == DEPTH_C);
  assign count = cnt_q;
  // an empty queue forwards the incoming word so a same-cycle pop sees it
  assign head  = empty ? push_data : mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt_q;
    if (push) wr_ptr_nxt = wr_ptr + PTR_W'(1);
    if (pop)  rd_ptr_nxt = rd_ptr + PTR_W'(1);
    unique case ({push, pop})
      2'b10:   cnt_nxt = cnt_q + CNT_W'(1);
      2'b01:   cnt_nxt = cnt_q - CNT_W'(1);
      default: cnt_nxt = cnt_q;
    endcase
  end

  assign state_en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (state_en) begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/msg_chan_core_if.sv
module msg_chan_core_if
  import msg_chan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter logic [NUM_CH-1:0] CH_DIR = 8'h0F,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     core_req,
  input  logic [1:0]               core_op,
  input  logic [CH_W-1:0]          core_ch,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_flat,
  input  logic [NUM_CH*DATA_W-1:0] head_flat,
  input  logic [NUM_CH-1:0]        full,
  input  logic [NUM_CH-1:0]        empty,
  input  logic [NUM_CH-1:0]        dev_take,
  input  logic [NUM_CH-1:0]        dev_give,
  output logic                     done,
  output logic                     err,
  output logic                     stall,
  output logic                     wr_fire,
  output logic                     rd_fire,
  output logic [DATA_W-1:0]        rdata
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  chan_op_e          op;
  logic              to_dev;
  logic [CNT_W-1:0]  sel_cnt;
  logic [DATA_W-1:0] sel_head;

  assign op       = chan_op_e'(core_op);
  assign to_dev   = CH_DIR[core_ch];
  assign sel_cnt  = cnt_flat[core_ch*CNT_W +: CNT_W];
  assign sel_head = head_flat[core_ch*DATA_W +: DATA_W];

  always_comb begin
    done    = 1'b0;
    err     = 1'b0;
    wr_fire = 1'b0;
    rd_fire = 1'b0;
    rdata   = '0;
    if (core_req) begin
      unique case (op)
        OP_READ: begin
          if (to_dev) begin
            done = 1'b1;
            err  = 1'b1;
          end else begin
            done    = ~empty[core_ch] | dev_give[core_ch];
            rd_fire = done;
            rdata   = sel_head;
          end
        end
        OP_WRITE: begin
          if (!to_dev) begin
            done = 1'b1;
            err  = 1'b1;
          end else begin
            done    = ~full[core_ch] | dev_take[core_ch];
            wr_fire = done;
          end
        end
        OP_COUNT: begin
          done  = 1'b1;
          rdata = DATA_W'(to_dev ? (DEPTH_C - sel_cnt) : sel_cnt);
        end
        default: begin
          done = 1'b1;
          err  = 1'b1;
        end
      endcase
    end
  end

  assign stall = core_req & ~done;
endmodule

// File: rtl/msg_chan_unit.sv
module msg_chan_unit #(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter logic [NUM_CH-1:0] CH_DIR = 8'h0F,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_req,
  input  logic [1:0]               core_op,
  input  logic [CH_W-1:0]          core_ch,
  input  logic [DATA_W-1:0]        core_wdata,
  output logic                     core_done,
  output logic                     core_err,
  output logic                     core_wait,
  output logic [DATA_W-1:0]        core_rdata,
  output logic [NUM_CH-1:0]        dev_out_valid,
  input  logic [NUM_CH-1:0]        dev_out_ready,
  output logic [NUM_CH*DATA_W-1:0] dev_out_data,
  input  logic [NUM_CH-1:0]        dev_in_valid,
  output logic [NUM_CH-1:0]        dev_in_ready,
  input  logic [NUM_CH*DATA_W-1:0] dev_in_data
);
  logic [NUM_CH-1:0]        push, pop, full, empty, dev_take, dev_give;
  logic [DATA_W-1:0]        push_data [NUM_CH];
  logic [DATA_W-1:0]        head      [NUM_CH];
  logic [CNT_W-1:0]         cnt       [NUM_CH];
  logic [NUM_CH*CNT_W-1:0]  cnt_flat;
  logic [NUM_CH*DATA_W-1:0] head_flat;
  logic                     wr_fire, rd_fire;
  logic                     unused_dev;

  // device inputs of the opposite direction are deliberately not consumed
  assign unused_dev = ^{dev_in_valid, dev_in_data, dev_out_ready};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cnt_flat[c*CNT_W +: CNT_W]    = cnt[c];
    assign head_flat[c*DATA_W +: DATA_W] = head[c];

    if (CH_DIR[c]) begin : g_to_dev
      assign push[c]      = wr_fire & (core_ch == CH_W'(c));
      assign push_data[c] = core_wdata;
      assign pop[c]       = dev_out_valid[c] & dev_out_ready[c];
      assign dev_take[c]  = pop[c];
      assign dev_give[c]  = 1'b0;
      assign dev_out_valid[c] = ~empty[c];
      assign dev_out_data[c*DATA_W +: DATA_W] = head[c];
      assign dev_in_ready[c]  = 1'b0;
    end else begin : g_to_core
      assign push[c]      = dev_in_valid[c] & dev_in_ready[c];
      assign push_data[c] = dev_in_data[c*DATA_W +: DATA_W];
      assign pop[c]       = rd_fire & (core_ch == CH_W'(c));
      assign dev_take[c]  = 1'b0;
      assign dev_give[c]  = push[c];
      assign dev_out_valid[c] = 1'b0;
      assign dev_out_data[c*DATA_W +: DATA_W] = '0;
      assign dev_in_ready[c]  = ~full[c];
    end

    msg_chan_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[c]),
      .push_data (push_data[c]),
      .pop       (pop[c]),
      .head      (head[c]),
      .count     (cnt[c]),
      .full      (full[c]),
      .empty     (empty[c])
    );
  end

  msg_chan_core_if #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W), .CH_DIR(CH_DIR)
  ) u_core (
    .core_req  (core_req),
    .core_op   (core_op),
    .core_ch   (core_ch),
    .cnt_flat  (cnt_flat),
    .head_flat (head_flat),
    .full      (full),
    .empty     (empty),
    .dev_take  (dev_take),
    .dev_give  (dev_give),
    .done      (core_done),
    .err       (core_err),
    .stall     (core_wait),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .rdata     (core_rdata)
  );
endmodule

// File: rtl/msg_chan_chk.sv
module msg_chan_chk #(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 4,
  parameter logic [NUM_CH-1:0] CH_DIR = 8'h0F,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    core_req,
  input logic [1:0]              core_op,
  input logic [CH_W-1:0]         core_ch,
  input logic                    core_done,
  input logic                    core_err,
  input logic                    core_wait,
  input logic [NUM_CH-1:0]       dev_out_valid,
  input logic [NUM_CH-1:0]       dev_in_ready,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // R4
  wr_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wait && core_op == 2'b01) |-> cnt_flat[core_ch*CNT_W +: CNT_W] == DEPTH_C);

  // R4
  rd_stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wait && core_op == 2'b00) |-> cnt_flat[core_ch*CNT_W +: CNT_W] == '0);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_err |-> (core_done && core_req && !core_wait));

  // R10
  wait_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_wait |-> (core_op == 2'b00 || core_op == 2'b01));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[c*CNT_W +: CNT_W] <= DEPTH_C);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[c*CNT_W +: CNT_W] == $past(cnt_flat[c*CNT_W +: CNT_W])) ||
      (cnt_flat[c*CNT_W +: CNT_W] == $past(cnt_flat[c*CNT_W +: CNT_W]) + CNT_W'(1)) ||
      (cnt_flat[c*CNT_W +: CNT_W] + CNT_W'(1) == $past(cnt_flat[c*CNT_W +: CNT_W])));

    if (CH_DIR[c]) begin : g_o
      // R11
      out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid[c] == (cnt_flat[c*CNT_W +: CNT_W] != '0));
    end else begin : g_i
      // R11
      in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_ready[c] == (cnt_flat[c*CNT_W +: CNT_W] != DEPTH_C));
    end
  end
endmodule

bind msg_chan_unit msg_chan_chk #(
  .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CH_DIR(CH_DIR)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_req      (core_req),
  .core_op       (core_op),
  .core_ch       (core_ch),
  .core_done     (core_done),
  .core_err      (core_err),
  .core_wait     (core_wait),
  .dev_out_valid (dev_out_valid),
  .dev_in_ready  (dev_in_ready),
  .cnt_flat      (cnt_flat)
);

// File: tb/sim_msg_chan_unit.sv
`timescale 1ns/1ps
module sim_msg_chan_unit;
  localparam int NCH = 8;
  localparam int DP  = 4;
  localparam logic [7:0] WMASK = 8'h0F;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         core_req;
  logic [1:0]   core_op;
  logic [2:0]   core_ch;
  logic [31:0]  core_wdata;
  logic         core_done, core_err, core_wait;
  logic [31:0]  core_rdata;
  logic [7:0]   dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready;
  logic [255:0] dev_out_data, dev_in_data;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [31:0] mq [NCH][$];

  always #10 clk = ~clk;

  msg_chan_unit u0 (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_op(core_op),
    .core_ch(core_ch), .core_wdata(core_wdata), .core_done(core_done),
    .core_err(core_err), .core_wait(core_wait), .core_rdata(core_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
    .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int qsize(input int c);
    return mq[c].size();
  endfunction

  // one cycle: inputs already set after a falling edge
  task automatic step(input string tag);
    logic [7:0]  e_ov, e_ir, takec, givec;
    logic        e_done, e_err, rd_f, wr_f, chk_rd;
    logic [31:0] e_rd;
    int          ch;
    #4;
    e_ov = '0; e_ir = '0; takec = '0; givec = '0;
    for (int c = 0; c < NCH; c++) begin
      if (WMASK[c]) begin
        e_ov[c]  = (qsize(c) > 0);
        takec[c] = e_ov[c] & dev_out_ready[c];
      end else begin
        e_ir[c]  = (qsize(c) < DP);
        givec[c] = dev_in_valid[c] & e_ir[c];
      end
    end
    ch = int'(core_ch);
    e_done = 1'b0; e_err = 1'b0; e_rd = '0; rd_f = 1'b0; wr_f = 1'b0; chk_rd = 1'b0;
    if (core_req) begin
      case (core_op)
        2'b00: if (WMASK[ch]) begin e_done = 1; e_err = 1; end
               else begin
                 e_done = (qsize(ch) > 0) | givec[ch];
                 rd_f = e_done; chk_rd = e_done;
                 e_rd = (qsize(ch) > 0) ? mq[ch][0] : dev_in_data[ch*32 +: 32];
               end
        2'b01: if (!WMASK[ch]) begin e_done = 1; e_err = 1; end
               else begin
                 e_done = (qsize(ch) < DP) | takec[ch];
                 wr_f = e_done;
               end
        2'b10: begin
                 e_done = 1; chk_rd = 1;
                 e_rd = WMASK[ch] ? 32'(DP - qsize(ch)) : 32'(qsize(ch));
               end
        default: begin e_done = 1; e_err = 1; end
      endcase
    end
    chk(tag, "core_done", 32'(core_done), 32'(e_done));
    chk(tag, "core_err",  32'(core_err),  32'(e_err));
    chk(tag, "core_wait", 32'(core_wait), 32'(core_req & ~e_done));
    if (chk_rd) chk(tag, "core_rdata", core_rdata, e_rd);
    chk(tag, "dev_out_valid", 32'(dev_out_valid), 32'(e_ov));
    chk(tag, "dev_in_ready",  32'(dev_in_ready),  32'(e_ir));
    for (int c = 0; c < NCH; c++)
      if (e_ov[c]) chk(tag, "dev_out_data", dev_out_data[c*32 +: 32], mq[c][0]);
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (WMASK[c]) begin
        if (takec[c]) void'(mq[c].pop_front());
        if (wr_f && c == ch) mq[c].push_back(core_wdata);
      end else begin
        if (rd_f && c == ch && qsize(c) == 0) begin
          // bypass: nothing stored
        end else begin
          if (rd_f && c == ch) void'(mq[c].pop_front());
          if (givec[c]) mq[c].push_back(dev_in_data[c*32 +: 32]);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    core_req = 0; core_op = 0; core_ch = 0; core_wdata = 0;
    dev_out_ready = 0; dev_in_valid = 0; dev_in_data = '0;
  endtask

  task automatic req(input logic [1:0] op, input int ch, input logic [31:0] wd);
    core_req = 1; core_op = op; core_ch = 3'(ch); core_wdata = wd;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state through count queries
    for (int c = 0; c < NCH; c++) begin req(2'b10, c, 0); step("R9"); end
    // R2 four back-to-back writes to channel 0
    for (int i = 0; i < 4; i++) begin req(2'b01, 0, 32'hA000 + i); step("R2"); end
    // R4 fifth write stalls
    req(2'b01, 0, 32'hA004);
    repeat (3) step("R4");
    // R5 completes in the cycle the device takes
    dev_out_ready[0] = 1; step("R5");
    idle();
    // R7 count query: zero free
    req(2'b10, 0, 0); step("R7");
    core_req = 0; dev_out_ready[0] = 1;
    repeat (5) step("R2");
    // R6 wrong direction, then counts unchanged
    dev_out_ready = 0;
    req(2'b01, 5, 32'hDEAD); step("R6");
    req(2'b00, 1, 0); step("R6");
    req(2'b10, 5, 0); step("R6");
    req(2'b10, 1, 0); step("R6");
    // R10 reserved opcode
    req(2'b11, 2, 0); step("R10");
    // R4 / R5 stalled read then device delivers
    req(2'b00, 6, 0);
    repeat (2) step("R4");
    dev_in_valid[6] = 1; dev_in_data[6*32 +: 32] = 32'hBEEF0006; step("R5");
    idle();
    // R11 fill channel 7 until ready drops
    for (int i = 0; i < 6; i++) begin
      dev_in_valid[7] = 1; dev_in_data[7*32 +: 32] = 32'hC700 + i; step("R11");
    end
    idle();
    // R3 read back in order
    for (int i = 0; i < 4; i++) begin req(2'b00, 7, 0); step("R3"); end
    idle();
    // R8 simultaneous enqueue and dequeue on channel 4
    for (int i = 0; i < 2; i++) begin
      dev_in_valid[4] = 1; dev_in_data[4*32 +: 32] = 32'hD400 + i; step("R8");
    end
    req(2'b00, 4, 0); dev_in_data[4*32 +: 32] = 32'hD402; step("R8");
    dev_in_valid = 0; req(2'b10, 4, 0); step("R8");
    // R8 full write channel taken and written in one cycle
    idle();
    for (int i = 0; i < 4; i++) begin req(2'b01, 3, 32'hE300 + i); step("R8"); end
    req(2'b01, 3, 32'hE304); dev_out_ready[3] = 1; step("R8");
    dev_out_ready = 0; req(2'b10, 3, 0); step("R8");
    // R1 random traffic over all channels
    for (int n = 0; n < 4000; n++) begin
      core_req      = ($urandom_range(0, 3) != 0);
      core_op       = ($urandom_range(0, 9) < 9) ? 2'($urandom_range(0, 2)) : 2'b11;
      core_ch       = 3'($urandom_range(0, 7));
      core_wdata    = $urandom;
      dev_out_ready = 8'($urandom) & 8'($urandom);
      dev_in_valid  = 8'($urandom) & 8'($urandom);
      for (int c = 0; c < NCH; c++) dev_in_data[c*32 +: 32] = $urandom;
      step("R1");
    end
    idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule